// File: doc/BRIEF.md
# DAC Output Override Controller

This block decides, for every channel of a multi-channel DAC core, which code the converter actually receives and which power/termination state it runs in. Its normal inputs are the stored channel codes and the stored per-channel power-down fields. These come from a register file that is outside this block. Six asynchronous active-low control pins can take precedence over the stored values. Three of them force a fixed code on every channel: all ones, midscale or zero. One of them, the lockout, holds every channel powered up. The last two force every channel into a terminated shutdown state.

Overrides never write into the stored data. When an override pin is released, the values held in the registers at that moment take effect again. This applies both to codes and to power-down fields, including any field that was rewritten while the override was active. The controller also reports combinations of pins that must not occur together. Each such combination is flagged on a registered output, and a fixed priority decides the result while it lasts.

Top module: `dac_output_override`

## Requirements
- R1: While the full-scale pin `full_n` is low and no higher-priority force pin is low, every channel's effective code is all ones (12'hFFF at the default width).
- R2: While the midscale pin `mid_n` is low and `zero_n` is high, every channel's effective code has only its most significant bit set (12'h800 at the default width).
- R3: While the zero-scale pin `zero_n` is low, every channel's effective code is zero.
- R4: While all three force pins are high, each channel's effective code equals its stored code. Releasing a force pin brings back the current stored code, so forcing never alters the stored value.
- R5: When more than one force pin is low, zero-scale wins over midscale, and midscale wins over full-scale.
- R6: `force_conflict` is 1 exactly when two or more of the three force pins are low (after synchronisation), and 0 otherwise.
- R7: Each channel has a 2-bit stored power field whose values are 00 run, 01 shutdown with 1 kΩ to ground, 10 shutdown with 100 kΩ, and 11 shutdown with outputs high-impedance. With both shutdown pins high, `pwr_mode` shows that field unchanged. While the lockout pin `lock_n` is low, every channel's `pwr_mode` is 00.
- R8: When `lock_n` goes high, each channel's `pwr_mode` is its stored field at that time. This is the original field if the field was untouched, or the new field if it was rewritten during the lockout.
- R9: While `sd1k_n` is low, every channel's `pwr_mode` is 01.
- R10: While `sdfar_n` is low and `sd1k_n` is high, every channel's `pwr_mode` is 10 when parameter `HIZ_OUT` is 0, and 11 when it is 1.
- R11: The shutdown pins take precedence over the lockout pin, and `sd1k_n` takes precedence over `sdfar_n`.
- R12: `pwr_conflict` is 1 exactly when `lock_n` is low together with at least one shutdown pin low, and 0 otherwise.
- R13: A change on an asynchronous pin reaches the outputs on the third rising clock edge after it is sampled. A change on a stored code or power field reaches the outputs on the next rising edge.
- R14: While `rst_n` is low, all effective codes are zero, all `pwr_mode` fields are 00, and both conflict flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_n | input | 1 | Async, force all-ones code when low |
| mid_n | input | 1 | Async, force midscale code when low |
| zero_n | input | 1 | Async, force zero code when low |
| lock_n | input | 1 | Async, hold channels powered up when low |
| sd1k_n | input | 1 | Async, shutdown with 1 kΩ termination when low |
| sdfar_n | input | 1 | Async, shutdown with 100 kΩ or high-impedance outputs when low |
| reg_code | input | NCH*CODE_W | Stored channel codes, channel 0 in the low bits |
| reg_pd | input | NCH*2 | Stored power fields, channel 0 in the low bits |
| eff_code | output | NCH*CODE_W | Effective codes to the DAC core |
| pwr_mode | output | NCH*2 | Effective power/termination mode per channel |
| force_conflict | output | 1 | More than one force pin is active |
| pwr_conflict | output | 1 | Lockout is active together with a shutdown pin |

## Verification
The hardest case to reach from the ports is the lockout-release rule. The stored power field must be shut down before the lockout, stay untouched or be rewritten during it, and only then is the pin released. The stimulus table walks that sequence in consecutive rows: a shut-down field, lockout asserted, release with the field unchanged, lockout again with a rewritten field, and a second release. The outputs are checked after each row. A second instance built with `HIZ_OUT` set receives the same pins, so both far-shutdown encodings are observed.

// File: rtl/dac_ovr_pkg.sv
package dac_ovr_pkg;

  typedef enum logic [1:0] {
    PM_RUN      = 2'b00,
    PM_TERM_1K  = 2'b01,
    PM_TERM_FAR = 2'b10,
    PM_HIZ      = 2'b11
  } pwr_mode_t;

  localparam int unsigned NUM_ASYNC = 6;
  localparam int unsigned IX_FULL   = 0;
  localparam int unsigned IX_MID    = 1;
  localparam int unsigned IX_ZERO   = 2;
  localparam int unsigned IX_LOCK   = 3;
  localparam int unsigned IX_SD1K   = 4;
  localparam int unsigned IX_SDFAR  = 5;

endpackage

// File: rtl/dac_ovr_sync.sv
module dac_ovr_sync #(
  parameter int unsigned WIDTH   = 6,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    logic meta_d;
    logic stab_d;

    always_comb begin
      meta_d = async_in[g];
      stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= meta_d;
        stab_q <= stab_d;
      end
    end

    assign sync_out[g] = stab_q;
  end

endmodule

// File: rtl/dac_ovr_code.sv
module dac_ovr_code #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              full_n,
  input  logic              mid_n,
  input  logic              zero_n,
  input  logic [CODE_W-1:0] stored,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;

  always_comb begin
    if (!zero_n)      code = CODE_ZERO;
    else if (!mid_n)  code = CODE_MID;
    else if (!full_n) code = CODE_FULL;
    else              code = stored;
  end

endmodule

// File: rtl/dac_ovr_power.sv
module dac_ovr_power
  import dac_ovr_pkg::*;
#(
  parameter bit HIZ_OUT = 1'b0
) (
  input  logic       lock_n,
  input  logic       sd1k_n,
  input  logic       sdfar_n,
  input  logic [1:0] stored_pd,
  output logic [1:0] mode
);

  localparam pwr_mode_t FAR_MODE = HIZ_OUT ? PM_HIZ : PM_TERM_FAR;

  pwr_mode_t mode_sel;

  always_comb begin
    if (!sd1k_n)       mode_sel = PM_TERM_1K;
    else if (!sdfar_n) mode_sel = FAR_MODE;
    else if (!lock_n)  mode_sel = PM_RUN;
    else               mode_sel = pwr_mode_t'(stored_pd);
  end

  assign mode = mode_sel;

endmodule

// File: rtl/dac_output_override.sv
module dac_output_override
  import dac_ovr_pkg::*;
#(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned NCH     = 2,
  parameter bit          HIZ_OUT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  full_n,
  input  logic                  mid_n,
  input  logic                  zero_n,
  input  logic                  lock_n,
  input  logic                  sd1k_n,
  input  logic                  sdfar_n,
  input  logic [NCH*CODE_W-1:0] reg_code,
  input  logic [NCH*2-1:0]      reg_pd,
  output logic [NCH*CODE_W-1:0] eff_code,
  output logic [NCH*2-1:0]      pwr_mode,
  output logic                  force_conflict,
  output logic                  pwr_conflict
);

  localparam int unsigned CODE_BITS = NCH * CODE_W;
  localparam int unsigned MODE_BITS = NCH * 2;

  logic [NUM_ASYNC-1:0] raw_pins;
  logic [NUM_ASYNC-1:0] sy_pins;
  logic sy_full_n, sy_mid_n, sy_zero_n, sy_lock_n, sy_sd1k_n, sy_sdfar_n;

  always_comb begin
    raw_pins            = '1;
    raw_pins[IX_FULL]   = full_n;
    raw_pins[IX_MID]    = mid_n;
    raw_pins[IX_ZERO]   = zero_n;
    raw_pins[IX_LOCK]   = lock_n;
    raw_pins[IX_SD1K]   = sd1k_n;
    raw_pins[IX_SDFAR]  = sdfar_n;
  end

  dac_ovr_sync #(.WIDTH(NUM_ASYNC), .RST_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_pins),
    .sync_out (sy_pins)
  );

  assign sy_full_n  = sy_pins[IX_FULL];
  assign sy_mid_n   = sy_pins[IX_MID];
  assign sy_zero_n  = sy_pins[IX_ZERO];
  assign sy_lock_n  = sy_pins[IX_LOCK];
  assign sy_sd1k_n  = sy_pins[IX_SD1K];
  assign sy_sdfar_n = sy_pins[IX_SDFAR];

  logic [CODE_BITS-1:0] code_nxt;
  logic [MODE_BITS-1:0] mode_nxt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_ovr_code #(.CODE_W(CODE_W)) u_code (
      .full_n (sy_full_n),
      .mid_n  (sy_mid_n),
      .zero_n (sy_zero_n),
      .stored (reg_code[ch*CODE_W +: CODE_W]),
      .code   (code_nxt[ch*CODE_W +: CODE_W])
    );

    dac_ovr_power #(.HIZ_OUT(HIZ_OUT)) u_pwr (
      .lock_n    (sy_lock_n),
      .sd1k_n    (sy_sd1k_n),
      .sdfar_n   (sy_sdfar_n),
      .stored_pd (reg_pd[ch*2 +: 2]),
      .mode      (mode_nxt[ch*2 +: 2])
    );
  end

  logic [1:0] force_cnt;
  logic       fconf_nxt;
  logic       pconf_nxt;

  always_comb begin
    force_cnt = {1'b0, ~sy_full_n} + {1'b0, ~sy_mid_n} + {1'b0, ~sy_zero_n};
    fconf_nxt = (force_cnt > 2'd1);
    pconf_nxt = ~sy_lock_n & (~sy_sd1k_n | ~sy_sdfar_n);
  end

  logic code_en, mode_en, flag_en;

  always_comb begin
    code_en = (code_nxt != eff_code);
    mode_en = (mode_nxt != pwr_mode);
    flag_en = (fconf_nxt != force_conflict) || (pconf_nxt != pwr_conflict);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_code <= '0;
    end else if (code_en) begin
      eff_code <= code_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_mode <= '0;
    end else if (mode_en) begin
      pwr_mode <= mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_conflict <= 1'b0;
      pwr_conflict   <= 1'b0;
    end else if (flag_en) begin
      force_conflict <= fconf_nxt;
      pwr_conflict   <= pconf_nxt;
    end
  end

endmodule

// File: rtl/dac_output_override_chk.sv
module dac_output_override_chk #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned NCH     = 2,
  parameter bit          HIZ_OUT = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sy_full_n,
  input logic                  sy_mid_n,
  input logic                  sy_zero_n,
  input logic                  sy_lock_n,
  input logic                  sy_sd1k_n,
  input logic                  sy_sdfar_n,
  input logic [NCH*CODE_W-1:0] reg_code,
  input logic [NCH*2-1:0]      reg_pd,
  input logic [NCH*CODE_W-1:0] eff_code,
  input logic [NCH*2-1:0]      pwr_mode,
  input logic                  force_conflict,
  input logic                  pwr_conflict
);

  localparam logic [NCH*CODE_W-1:0] ALL_FULL = '1;
  localparam logic [NCH*CODE_W-1:0] ALL_MID  = {NCH{1'b1, {(CODE_W-1){1'b0}}}};
  localparam logic [NCH*2-1:0]      ALL_1K   = {NCH{2'b01}};
  localparam logic [NCH*2-1:0]      ALL_FAR  = {NCH{HIZ_OUT ? 2'b11 : 2'b10}};

  // R1
  full_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_full_n && sy_mid_n && sy_zero_n) |=> (eff_code == ALL_FULL));

  // R2
  mid_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_mid_n && sy_zero_n) |=> (eff_code == ALL_MID));

  // R3
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_zero_n) |=> (eff_code == '0));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sy_full_n && sy_mid_n && sy_zero_n) |=> (eff_code == $past(reg_code)));

  // R6
  force_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (force_conflict == ($countones({~$past(sy_full_n), ~$past(sy_mid_n), ~$past(sy_zero_n)}) > 1)));

  // R7
  lockout_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_lock_n && sy_sd1k_n && sy_sdfar_n) |=> (pwr_mode == '0));

  // R7
  stored_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sy_lock_n && sy_sd1k_n && sy_sdfar_n) |=> (pwr_mode == $past(reg_pd)));

  // R9
  sd_1k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_sd1k_n) |=> (pwr_mode == ALL_1K));

  // R10
  sd_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sy_sdfar_n && sy_sd1k_n) |=> (pwr_mode == ALL_FAR));

  // R12
  pwr_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwr_conflict == ($past(!sy_lock_n) && ($past(!sy_sd1k_n) || $past(!sy_sdfar_n)))));

endmodule

bind dac_output_override dac_output_override_chk #(
  .CODE_W (CODE_W),
  .NCH    (NCH),
  .HIZ_OUT(HIZ_OUT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sy_full_n      (sy_full_n),
  .sy_mid_n       (sy_mid_n),
  .sy_zero_n      (sy_zero_n),
  .sy_lock_n      (sy_lock_n),
  .sy_sd1k_n      (sy_sd1k_n),
  .sy_sdfar_n     (sy_sdfar_n),
  .reg_code       (reg_code),
  .reg_pd         (reg_pd),
  .eff_code       (eff_code),
  .pwr_mode       (pwr_mode),
  .force_conflict (force_conflict),
  .pwr_conflict   (pwr_conflict)
);

// File: tb/dac_output_override_tb.sv
module dac_output_override_tb;

  localparam int CW   = 12;
  localparam int NCH  = 2;
  localparam int NVEC = 20;

  logic clk;
  logic rst_n;
  logic full_n, mid_n, zero_n, lock_n, sd1k_n, sdfar_n;
  logic [NCH*CW-1:0] reg_code;
  logic [NCH*2-1:0]  reg_pd;
  logic [NCH*CW-1:0] eff_code, eff_code_hz;
  logic [NCH*2-1:0]  pwr_mode, pwr_mode_hz;
  logic fconf, pconf, fconf_hz, pconf_hz;

  int n_tests;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dac_output_override #(.CODE_W(CW), .NCH(NCH), .HIZ_OUT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .full_n(full_n), .mid_n(mid_n), .zero_n(zero_n),
    .lock_n(lock_n), .sd1k_n(sd1k_n), .sdfar_n(sdfar_n),
    .reg_code(reg_code), .reg_pd(reg_pd),
    .eff_code(eff_code), .pwr_mode(pwr_mode),
    .force_conflict(fconf), .pwr_conflict(pconf)
  );

  dac_output_override #(.CODE_W(CW), .NCH(NCH), .HIZ_OUT(1'b1)) u_dut_hz (
    .clk(clk), .rst_n(rst_n),
    .full_n(full_n), .mid_n(mid_n), .zero_n(zero_n),
    .lock_n(lock_n), .sd1k_n(sd1k_n), .sdfar_n(sdfar_n),
    .reg_code(reg_code), .reg_pd(reg_pd),
    .eff_code(eff_code_hz), .pwr_mode(pwr_mode_hz),
    .force_conflict(fconf_hz), .pwr_conflict(pconf_hz)
  );

  // Row: pins {full,mid,zero,lock,sd1k,sdfar}, code ch1, code ch0, pd ch1, pd ch0,
  //      expected code ch1, code ch0, mode ch1, mode ch0, force_conflict, pwr_conflict
  localparam logic [63:0] VEC [0:NVEC-1] = '{
    {6'b111111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h123, 12'hABC, 2'b00, 2'b00, 1'b0, 1'b0}, // R4
    {6'b011111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'hFFF, 12'hFFF, 2'b00, 2'b00, 1'b0, 1'b0}, // R1
    {6'b101111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h800, 12'h800, 2'b00, 2'b00, 1'b0, 1'b0}, // R2
    {6'b110111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h000, 12'h000, 2'b00, 2'b00, 1'b0, 1'b0}, // R3
    {6'b111111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h123, 12'hABC, 2'b00, 2'b00, 1'b0, 1'b0}, // R4 resume
    {6'b001111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h800, 12'h800, 2'b00, 2'b00, 1'b1, 1'b0}, // R5
    {6'b010111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h000, 12'h000, 2'b00, 2'b00, 1'b1, 1'b0}, // R5
    {6'b000111, 12'h123, 12'hABC, 2'b00, 2'b00, 12'h000, 12'h000, 2'b00, 2'b00, 1'b1, 1'b0}, // R6
    {6'b111111, 12'h5A5, 12'h0F0, 2'b01, 2'b10, 12'h5A5, 12'h0F0, 2'b01, 2'b10, 1'b0, 1'b0}, // R7
    {6'b111011, 12'h5A5, 12'h0F0, 2'b01, 2'b10, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 1'b0, 1'b0}, // R7
    {6'b111111, 12'h5A5, 12'h0F0, 2'b01, 2'b10, 12'h5A5, 12'h0F0, 2'b01, 2'b10, 1'b0, 1'b0}, // R8
    {6'b111011, 12'h5A5, 12'h0F0, 2'b11, 2'b00, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 1'b0, 1'b0}, // R7
    {6'b111111, 12'h5A5, 12'h0F0, 2'b11, 2'b00, 12'h5A5, 12'h0F0, 2'b11, 2'b00, 1'b0, 1'b0}, // R8
    {6'b111101, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 12'h5A5, 12'h0F0, 2'b01, 2'b01, 1'b0, 1'b0}, // R9
    {6'b111110, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 12'h5A5, 12'h0F0, 2'b10, 2'b10, 1'b0, 1'b0}, // R10
    {6'b111100, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 12'h5A5, 12'h0F0, 2'b01, 2'b01, 1'b0, 1'b0}, // R11
    {6'b111001, 12'h5A5, 12'h0F0, 2'b10, 2'b11, 12'h5A5, 12'h0F0, 2'b01, 2'b01, 1'b0, 1'b1}, // R11
    {6'b111010, 12'h5A5, 12'h0F0, 2'b00, 2'b00, 12'h5A5, 12'h0F0, 2'b10, 2'b10, 1'b0, 1'b1}, // R12
    {6'b011100, 12'h321, 12'h654, 2'b00, 2'b00, 12'hFFF, 12'hFFF, 2'b01, 2'b01, 1'b0, 1'b0}, // R1
    {6'b111111, 12'h321, 12'h654, 2'b00, 2'b00, 12'h321, 12'h654, 2'b00, 2'b00, 1'b0, 1'b0}  // R4
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 4, 19: return "R4";
      1, 18:    return "R1";
      2:        return "R2";
      3:        return "R3";
      5, 6:     return "R5";
      7:        return "R6";
      8, 9, 11: return "R7";
      10, 12:   return "R8";
      13:       return "R9";
      14:       return "R10";
      15, 16:   return "R11";
      default:  return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_pins(input logic [5:0] p);
    {full_n, mid_n, zero_n, lock_n, sd1k_n, sdfar_n} = p;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    drive_pins(6'b111111);
    reg_code = {12'h111, 12'h222};
    reg_pd   = {2'b01, 2'b11};

    // R14: reset state
    repeat (3) @(negedge clk);
    check("R14", "reset code", 64'(eff_code), 64'h0);
    check("R14", "reset mode", 64'(pwr_mode), 64'h0);
    check("R14", "reset flags", 64'({fconf, pconf}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      drive_pins(v[63:58]);
      reg_code = v[57:34];
      reg_pd   = v[33:30];
      repeat (4) @(negedge clk);
      check(vec_tag(i), $sformatf("row %0d code", i), 64'(eff_code), 64'(v[29:6]));
      check(vec_tag(i), $sformatf("row %0d mode", i), 64'(pwr_mode), 64'(v[5:2]));
      check(vec_tag(i), $sformatf("row %0d flags", i), 64'({fconf, pconf}), 64'(v[1:0]));
    end

    // R10: high-impedance variant, far shutdown gives 11
    drive_pins(6'b111110);
    repeat (4) @(negedge clk);
    check("R10", "hiz variant mode", 64'(pwr_mode_hz), 64'({2'b11, 2'b11}));
    check("R10", "plain variant mode", 64'(pwr_mode), 64'({2'b10, 2'b10}));
    drive_pins(6'b111111);
    repeat (4) @(negedge clk);

    // R13: async pin latency of three edges
    reg_code = {12'h3C3, 12'h0A0};
    @(negedge clk);
    // R13: stored code latency of one edge
    check("R13", "code after one edge", 64'(eff_code), 64'({12'h3C3, 12'h0A0}));
    drive_pins(6'b011111);
    repeat (2) @(negedge clk);
    check("R13", "code before third edge", 64'(eff_code), 64'({12'h3C3, 12'h0A0}));
    @(negedge clk);
    check("R13", "code after third edge", 64'(eff_code), 64'({12'hFFF, 12'hFFF}));

    // R4: stored code changed while forced shows once released
    reg_code = {12'h777, 12'h888};
    repeat (2) @(negedge clk);
    check("R4", "forced ignores stored change", 64'(eff_code), 64'({12'hFFF, 12'hFFF}));
    drive_pins(6'b111111);
    repeat (4) @(negedge clk);
    check("R4", "new stored code after release", 64'(eff_code), 64'({12'h777, 12'h888}));

    // R14: reset mid-operation clears outputs
    drive_pins(6'b110101);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R14", "reset again code", 64'(eff_code), 64'h0);
    check("R14", "reset again mode", 64'(pwr_mode), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule